// File: doc/BRIEF.md
# Deferred Draw-State Group Dispatcher

This block keeps a table of state groups for a command-stream front end. Each group has a small numeric identifier and a descriptor: a 3-bit mask of the render modes in which it may run, a start index, and a length. Together these point at a run of command words in an internal fragment memory. The host can rewrite any group descriptor and any fragment word at any time. A descriptor write always replaces the whole descriptor and marks the group as changed.

When a draw request arrives, it carries a tile-visibility flag and the current render mode. If the draw is not visible, nothing is replayed. If it is visible, the block walks the groups from the lowest identifier to the highest. It streams out the fragment of every group that has changed since it was last replayed and whose mode mask enables the current mode. The output carries one word per cycle under a valid/ready handshake. A group counts as replayed only once its last word has been taken downstream. Groups skipped because of their mode keep their pending status for a later draw in a matching mode.

Top module: `drawstate_dispatch`

## Requirements
- R1: After the synchronous active-high reset, `out_valid` and `draw_done` are low and `draw_ready` is high. No group is pending, so a visible draw in any mode emits no words.
- R2: A group write replaces the whole descriptor (mode mask, start, length) and marks the group pending. Only the most recent write to a group takes effect at the next draw.
- R3: A draw accepted with `draw_visible` low emits no words and changes no pending status. `draw_done` pulses in the cycle after acceptance.
- R4: A visible draw replays pending groups whose mask bit for the draw mode is set, in ascending group order. Mode codes are 0 = direct-to-memory, 1 = binning and 2 = tiled, and they select mask bits 0, 1 and 2. Code 3 selects no group.
- R5: A replayed group emits memory words start, start+1, ... for its length, with addresses wrapping modulo the memory depth. `out_gid` carries the group number and `out_last` is high only on the group's final word.
- R6: After a group's final word is accepted, the group is no longer pending. A repeated draw in the same mode emits nothing for it.
- R7: A pending group whose mask does not enable the draw mode stays pending and is replayed by a later draw in an enabled mode.
- R8: A pending, enabled group of length zero emits no words and does not disturb the replay of the other groups in the same draw.
- R9: While `out_valid` is high and `out_ready` is low, `out_data`, `out_gid` and `out_last` hold steady. No word is lost or duplicated under any ready pattern.
- R10: If a group is written while the same draw is replaying it, the draw completes with the old contents, the group stays pending, and the next enabled draw replays the new contents.
- R11: `draw_ready` is low from the acceptance of a visible draw until its completion. `draw_done` is only asserted while `draw_ready` is high.
- R12: With `out_ready` held high, the words of one group leave on consecutive cycles, so `out_valid` stays high for exactly as many cycles as the group's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| grp_wr_en | input | 1 | Group descriptor write strobe |
| grp_wr_id | input | GID_W | Group number to write |
| grp_wr_modes | input | 3 | Mode mask: bit0 direct, bit1 binning, bit2 tiled |
| grp_wr_start | input | ADDR_W | First fragment word index |
| grp_wr_len | input | ADDR_W+1 | Fragment length in words |
| frag_wr_en | input | 1 | Fragment memory write strobe |
| frag_wr_addr | input | ADDR_W | Fragment memory write address |
| frag_wr_data | input | WORD_W | Fragment memory write data |
| draw_valid | input | 1 | Draw request |
| draw_ready | output | 1 | Block idle, accepts a draw |
| draw_visible | input | 1 | Draw has a primitive in the current tile |
| draw_mode | input | 2 | Render mode code of the draw |
| draw_done | output | 1 | One-cycle completion pulse per draw |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the word |
| out_data | output | WORD_W | Replayed command word |
| out_gid | output | GID_W | Group the word belongs to |
| out_last | output | 1 | Final word of the group |

## Verification
The bench targets fragments that wrap past the end of the memory, zero-length groups, the reserved mode code, and a group rewritten while its own replay is stalled. A design that got these wrong would read the wrong words after the wrap, hang or emit a stray word, replay something for mode 3, or drop the rewrite so that the next draw emits nothing. Repeated draws in one mode catch a design that never clears its pending flags. Draws in a non-matching mode before a matching one catch a design that clears flags too eagerly. Random ready patterns and random group traffic then expose words lost or repeated under backpressure, as well as out-of-order groups.

// File: rtl/drawstate_pkg.sv
package drawstate_pkg;

  localparam int NUM_MODES = 3;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SCAN  = 2'd1,
    ST_EMIT  = 2'd2,
    ST_DRAIN = 2'd3
  } disp_state_e;

  // Render mode code to mask bit; code 3 matches nothing.
  function automatic logic mode_hit(input logic [NUM_MODES-1:0] mask,
                                    input logic [1:0] code);
    logic hit;
    hit = 1'b0;
    for (int m = 0; m < NUM_MODES; m++) begin
      if (code == 2'(m) && mask[m]) hit = 1'b1;
    end
    return hit;
  endfunction

endpackage

// File: rtl/drawstate_fragram.sv
module drawstate_fragram #(
  parameter int DEPTH  = 256,
  parameter int WORD_W = 32,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data
);

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  // Registered read with enable: the register doubles as the output stage.
  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
  end

endmodule

// File: rtl/drawstate_pick.sv
module drawstate_pick #(
  parameter int N     = 32,
  localparam int IDX_W = $clog2(N),
  localparam int LO_W  = IDX_W + 1
) (
  input  logic [N-1:0]     req,
  input  logic [LO_W-1:0]  lo,
  output logic             found,
  output logic [IDX_W-1:0] idx
);

  // Lowest requesting index at or above lo.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i] && (LO_W'(i) >= lo)) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/drawstate_table.sv
module drawstate_table import drawstate_pkg::*; #(
  parameter int NUM_GROUPS = 32,
  parameter int ADDR_W     = 8,
  localparam int GID_W = $clog2(NUM_GROUPS),
  localparam int LEN_W = ADDR_W + 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [GID_W-1:0]      wr_id,
  input  logic [NUM_MODES-1:0]  wr_modes,
  input  logic [ADDR_W-1:0]     wr_start,
  input  logic [LEN_W-1:0]      wr_len,
  input  logic                  clr_en,
  input  logic [GID_W-1:0]      clr_id,
  input  logic [1:0]            mode_sel,
  output logic [NUM_GROUPS-1:0] elig,
  input  logic [GID_W-1:0]      rd_id,
  output logic [ADDR_W-1:0]     rd_start,
  output logic [LEN_W-1:0]      rd_len
);

  logic [NUM_MODES-1:0] modes_q [NUM_GROUPS];
  logic [ADDR_W-1:0]    start_q [NUM_GROUPS];
  logic [LEN_W-1:0]     len_q   [NUM_GROUPS];
  logic [NUM_GROUPS-1:0] dirty_q;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    // A write wins over a same-cycle clear, so a rewrite is never lost.
    always_ff @(posedge clk) begin
      if (rst) begin
        dirty_q[g] <= 1'b0;
        modes_q[g] <= '0;
        start_q[g] <= '0;
        len_q[g]   <= '0;
      end else if (wr_en && wr_id == GID_W'(g)) begin
        dirty_q[g] <= 1'b1;
        modes_q[g] <= wr_modes;
        start_q[g] <= wr_start;
        len_q[g]   <= wr_len;
      end else if (clr_en && clr_id == GID_W'(g)) begin
        dirty_q[g] <= 1'b0;
      end
    end

    assign elig[g] = dirty_q[g] && mode_hit(modes_q[g], mode_sel);
  end

  assign rd_start = start_q[rd_id];
  assign rd_len   = len_q[rd_id];

endmodule

// File: rtl/drawstate_dispatch.sv
module drawstate_dispatch import drawstate_pkg::*; #(
  parameter int NUM_GROUPS = 32,
  parameter int FRAG_DEPTH = 256,
  parameter int WORD_W     = 32,
  localparam int GID_W  = $clog2(NUM_GROUPS),
  localparam int ADDR_W = $clog2(FRAG_DEPTH),
  localparam int LEN_W  = ADDR_W + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 grp_wr_en,
  input  logic [GID_W-1:0]     grp_wr_id,
  input  logic [NUM_MODES-1:0] grp_wr_modes,
  input  logic [ADDR_W-1:0]    grp_wr_start,
  input  logic [LEN_W-1:0]     grp_wr_len,
  input  logic                 frag_wr_en,
  input  logic [ADDR_W-1:0]    frag_wr_addr,
  input  logic [WORD_W-1:0]    frag_wr_data,
  input  logic                 draw_valid,
  output logic                 draw_ready,
  input  logic                 draw_visible,
  input  logic [1:0]           draw_mode,
  output logic                 draw_done,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [WORD_W-1:0]    out_data,
  output logic [GID_W-1:0]     out_gid,
  output logic                 out_last
);

  disp_state_e           state;
  logic [GID_W:0]        ptr;
  logic [1:0]            cur_mode;
  logic [GID_W-1:0]      cur_gid;
  logic [ADDR_W-1:0]     rd_addr;
  logic [LEN_W-1:0]      left;
  logic                  rewr;

  logic [NUM_GROUPS-1:0] elig;
  logic                  pick_found;
  logic [GID_W-1:0]      pick_idx;
  logic [ADDR_W-1:0]     tbl_start;
  logic [LEN_W-1:0]      tbl_len;

  logic rd_en, scan_zero, drain_clr, clr_en;
  logic [GID_W-1:0] clr_id;

  assign draw_ready = (state == ST_IDLE);
  assign rd_en      = (state == ST_EMIT) && (!out_valid || out_ready);
  assign scan_zero  = (state == ST_SCAN) && pick_found && (tbl_len == '0);
  assign drain_clr  = (state == ST_DRAIN) && out_valid && out_ready && !rewr;
  assign clr_en     = scan_zero || drain_clr;
  assign clr_id     = scan_zero ? pick_idx : cur_gid;

  drawstate_table #(.NUM_GROUPS(NUM_GROUPS), .ADDR_W(ADDR_W)) u_table (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (grp_wr_en),
    .wr_id    (grp_wr_id),
    .wr_modes (grp_wr_modes),
    .wr_start (grp_wr_start),
    .wr_len   (grp_wr_len),
    .clr_en   (clr_en),
    .clr_id   (clr_id),
    .mode_sel (cur_mode),
    .elig     (elig),
    .rd_id    (pick_idx),
    .rd_start (tbl_start),
    .rd_len   (tbl_len)
  );

  drawstate_pick #(.N(NUM_GROUPS)) u_pick (
    .req   (elig),
    .lo    (ptr),
    .found (pick_found),
    .idx   (pick_idx)
  );

  drawstate_fragram #(.DEPTH(FRAG_DEPTH), .WORD_W(WORD_W)) u_ram (
    .clk     (clk),
    .wr_en   (frag_wr_en),
    .wr_addr (frag_wr_addr),
    .wr_data (frag_wr_data),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_data (out_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      ptr       <= '0;
      cur_mode  <= '0;
      cur_gid   <= '0;
      rd_addr   <= '0;
      left      <= '0;
      rewr      <= 1'b0;
      out_valid <= 1'b0;
      out_gid   <= '0;
      out_last  <= 1'b0;
      draw_done <= 1'b0;
    end else begin
      draw_done <= 1'b0;
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (rd_en) begin
        out_valid <= 1'b1;
        out_gid   <= cur_gid;
        out_last  <= (left == LEN_W'(1));
        rd_addr   <= rd_addr + 1'b1;
        left      <= left - 1'b1;
      end
      if ((state == ST_EMIT || state == ST_DRAIN) && grp_wr_en && grp_wr_id == cur_gid)
        rewr <= 1'b1;

      case (state)
        ST_IDLE: begin
          if (draw_valid) begin
            if (draw_visible) begin
              state    <= ST_SCAN;
              ptr      <= '0;
              cur_mode <= draw_mode;
            end else begin
              draw_done <= 1'b1;
            end
          end
        end
        ST_SCAN: begin
          if (pick_found) begin
            cur_gid <= pick_idx;
            ptr     <= {1'b0, pick_idx} + 1'b1;
            if (tbl_len != '0) begin
              rd_addr <= tbl_start;
              left    <= tbl_len;
              rewr    <= grp_wr_en && (grp_wr_id == pick_idx);
              state   <= ST_EMIT;
            end
          end else begin
            draw_done <= 1'b1;
            state     <= ST_IDLE;
          end
        end
        ST_EMIT: begin
          if (rd_en && left == LEN_W'(1)) state <= ST_DRAIN;
        end
        ST_DRAIN: begin
          if (out_valid && out_ready) state <= ST_SCAN;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/drawstate_dispatch_chk.sv
module drawstate_dispatch_chk #(
  parameter int GID_W  = 5,
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              draw_valid,
  input logic              draw_ready,
  input logic              draw_visible,
  input logic              draw_done,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_last,
  input logic [GID_W-1:0]  out_gid,
  input logic [WORD_W-1:0] out_data
);

  logic [GID_W-1:0] last_gid_q;
  logic             seen_q;

  always_ff @(posedge clk) begin
    if (rst || draw_ready) begin
      seen_q     <= 1'b0;
      last_gid_q <= '0;
    end else if (out_valid && out_ready) begin
      seen_q     <= 1'b1;
      last_gid_q <= out_gid;
    end
  end

  p_reset_clean_r1: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && draw_ready && !draw_done));

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_data) && $stable(out_gid) && $stable(out_last)));

  p_invisible_r3: assert property (@(posedge clk) disable iff (rst)
    (draw_valid && draw_ready && !draw_visible) |=> (draw_done && !out_valid));

  p_busy_r11: assert property (@(posedge clk) disable iff (rst)
    (draw_valid && draw_ready && draw_visible) |=> (!draw_ready && !draw_done));

  p_done_idle_r11: assert property (@(posedge clk) disable iff (rst)
    draw_done |-> draw_ready);

  p_quiet_idle_r4: assert property (@(posedge clk) disable iff (rst)
    draw_ready |-> !out_valid);

  p_ascend_r4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && seen_q) |-> (out_gid >= last_gid_q));

endmodule

bind drawstate_dispatch drawstate_dispatch_chk #(.GID_W(GID_W), .WORD_W(WORD_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .draw_valid   (draw_valid),
  .draw_ready   (draw_ready),
  .draw_visible (draw_visible),
  .draw_done    (draw_done),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_last     (out_last),
  .out_gid      (out_gid),
  .out_data     (out_data)
);

// File: tb/drawstate_dispatch_tb.sv
`timescale 1ns/1ps
module drawstate_dispatch_tb;

  localparam int NG     = 32;
  localparam int DEPTH  = 256;
  localparam int WW     = 32;
  localparam int GW     = 5;
  localparam int AW     = 8;
  localparam int LW     = 9;
  localparam int MAXW   = 2048;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic          grp_wr_en = 0;
  logic [GW-1:0] grp_wr_id = 0;
  logic [2:0]    grp_wr_modes = 0;
  logic [AW-1:0] grp_wr_start = 0;
  logic [LW-1:0] grp_wr_len = 0;
  logic          frag_wr_en = 0;
  logic [AW-1:0] frag_wr_addr = 0;
  logic [WW-1:0] frag_wr_data = 0;
  logic          draw_valid = 0;
  logic          draw_ready;
  logic          draw_visible = 0;
  logic [1:0]    draw_mode = 0;
  logic          draw_done;
  logic          out_valid;
  logic          out_ready = 0;
  logic [WW-1:0] out_data;
  logic [GW-1:0] out_gid;
  logic          out_last;

  always #2.5 clk = ~clk;

  drawstate_dispatch u_dut (
    .clk(clk), .rst(rst),
    .grp_wr_en(grp_wr_en), .grp_wr_id(grp_wr_id), .grp_wr_modes(grp_wr_modes),
    .grp_wr_start(grp_wr_start), .grp_wr_len(grp_wr_len),
    .frag_wr_en(frag_wr_en), .frag_wr_addr(frag_wr_addr), .frag_wr_data(frag_wr_data),
    .draw_valid(draw_valid), .draw_ready(draw_ready), .draw_visible(draw_visible),
    .draw_mode(draw_mode), .draw_done(draw_done),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_gid(out_gid), .out_last(out_last)
  );

  // Reference model state
  logic [WW-1:0] m_mem   [DEPTH];
  logic          m_dirty [NG];
  logic [2:0]    m_modes [NG];
  logic [AW-1:0] m_start [NG];
  logic [LW-1:0] m_len   [NG];

  logic [GW-1:0] e_gid [MAXW];
  logic [WW-1:0] e_dat [MAXW];
  logic          e_lst [MAXW];
  logic [GW-1:0] g_gid [MAXW];
  logic [WW-1:0] g_dat [MAXW];
  logic          g_lst [MAXW];

  int n_checks = 0;
  int n_err    = 0;
  int last_vcnt = 0;
  int total_cyc = 0;
  bit finished = 0;

  task automatic chk(input string tag, input string what,
                     input logic [63:0] got, input logic [63:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  task automatic wr_group(input int id, input logic [2:0] modes,
                          input int start, input int len);
    grp_wr_en = 1; grp_wr_id = GW'(id); grp_wr_modes = modes;
    grp_wr_start = AW'(start); grp_wr_len = LW'(len);
    @(negedge clk);
    grp_wr_en = 0;
    m_dirty[id] = 1; m_modes[id] = modes; m_start[id] = AW'(start); m_len[id] = LW'(len);
  endtask

  task automatic do_draw(input string tag, input bit vis, input int mode, input int rpct,
                         input int hij, input logic [2:0] hmodes, input int hstart,
                         input int hlen);
    bit elig [NG];
    int ne, ng, cyc, vcnt;
    bit done, busy_bad, hdone, r;
    ne = 0; ng = 0; cyc = 0; vcnt = 0; done = 0; busy_bad = 0; hdone = 0;
    for (int g = 0; g < NG; g++) begin
      elig[g] = vis && mode < 3 && m_dirty[g] && m_modes[g][mode];
      if (elig[g]) begin
        for (int i = 0; i < int'(m_len[g]); i++) begin
          e_gid[ne] = GW'(g);
          e_dat[ne] = m_mem[(int'(m_start[g]) + i) % DEPTH];
          e_lst[ne] = (i == int'(m_len[g]) - 1);
          ne++;
        end
      end
    end
    draw_valid = 1; draw_visible = vis; draw_mode = 2'(mode);
    @(negedge clk);
    draw_valid = 0;
    while (!done) begin
      grp_wr_en = 0;
      if (draw_done) begin
        done = 1;
      end else begin
        if (draw_ready) busy_bad = 1;
        r = ($urandom % 100) < rpct;
        if (hij >= 0 && !hdone && out_valid && out_gid == GW'(hij)) begin
          r = 0;
          grp_wr_en = 1; grp_wr_id = GW'(hij); grp_wr_modes = hmodes;
          grp_wr_start = AW'(hstart); grp_wr_len = LW'(hlen);
          m_dirty[hij] = 1; m_modes[hij] = hmodes;
          m_start[hij] = AW'(hstart); m_len[hij] = LW'(hlen);
          hdone = 1;
        end
        out_ready = r;
        if (out_valid) vcnt++;
        if (out_valid && r && ng < MAXW) begin
          g_gid[ng] = out_gid; g_dat[ng] = out_data; g_lst[ng] = out_last; ng++;
        end
        cyc++;
        if (cyc > 20000) begin
          chk(tag, "draw never completed", 0, 1);
          done = 1;
        end
        @(negedge clk);
      end
    end
    out_ready = 0; grp_wr_en = 0;
    last_vcnt = vcnt;
    chk(tag, "word count", 64'(ng), 64'(ne));
    for (int k = 0; k < ng && k < ne; k++) begin
      chk(tag, "word gid", 64'(g_gid[k]), 64'(e_gid[k]));
      chk(tag, "word data", 64'(g_dat[k]), 64'(e_dat[k]));
      chk(tag, "word last", 64'(g_lst[k]), 64'(e_lst[k]));
    end
    if (vis) chk("R11", "draw_ready low while busy", 64'(busy_bad), 64'(0));
    else     chk("R3", "done latency of invisible draw", 64'(cyc), 64'(0));
    for (int g = 0; g < NG; g++)
      if (elig[g] && !(hdone && g == hij)) m_dirty[g] = 0;
  endtask

  always @(posedge clk) begin
    total_cyc++;
    if (total_cyc > 180000 && !finished) begin
      finished = 1;
      n_checks++; n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h0D15_EA5E));
    for (int g = 0; g < NG; g++) begin
      m_dirty[g] = 0; m_modes[g] = 0; m_start[g] = 0; m_len[g] = 0;
    end
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state
    chk("R1", "out_valid after reset", 64'(out_valid), 0);
    chk("R1", "draw_ready after reset", 64'(draw_ready), 1);
    chk("R1", "draw_done after reset", 64'(draw_done), 0);

    for (int a = 0; a < DEPTH; a++) begin
      frag_wr_en = 1; frag_wr_addr = AW'(a); frag_wr_data = $urandom;
      m_mem[a] = frag_wr_data;
      @(negedge clk);
    end
    frag_wr_en = 0;

    for (int m = 0; m < 3; m++) do_draw("R1", 1, m, 70, -1, 0, 0, 0);

    // R2: second write replaces the whole descriptor
    wr_group(3, 3'b001, 10, 4);
    wr_group(3, 3'b100, 40, 5);
    do_draw("R2", 1, 0, 80, -1, 0, 0, 0);
    do_draw("R2", 1, 2, 80, -1, 0, 0, 0);

    // R3: invisible draw changes nothing
    wr_group(6, 3'b111, 70, 3);
    do_draw("R3", 0, 1, 80, -1, 0, 0, 0);
    do_draw("R3", 1, 1, 80, -1, 0, 0, 0);

    // R4 / R7: ordering, mode filtering, skipped groups stay pending, code 3
    wr_group(20, 3'b010, 120, 2);
    wr_group(2, 3'b100, 130, 3);
    wr_group(9, 3'b111, 140, 2);
    do_draw("R4", 1, 2, 60, -1, 0, 0, 0);
    do_draw("R7", 1, 1, 60, -1, 0, 0, 0);
    wr_group(1, 3'b111, 150, 2);
    do_draw("R4", 1, 3, 60, -1, 0, 0, 0);
    do_draw("R7", 1, 0, 60, -1, 0, 0, 0);

    // R8: zero length among others
    wr_group(11, 3'b001, 160, 2);
    wr_group(12, 3'b001, 170, 0);
    wr_group(13, 3'b001, 180, 2);
    do_draw("R8", 1, 0, 60, -1, 0, 0, 0);

    // R5: wrap past end of memory
    wr_group(15, 3'b010, 254, 5);
    do_draw("R5", 1, 1, 40, -1, 0, 0, 0);

    // R12: back-to-back words with ready high
    wr_group(7, 3'b100, 100, 8);
    do_draw("R12", 1, 2, 100, -1, 0, 0, 0);
    chk("R12", "valid cycles for 8-word group", 64'(last_vcnt), 64'(8));

    // R6: repeat draw emits nothing
    do_draw("R6", 1, 2, 100, -1, 0, 0, 0);

    // R10: rewrite a group while it is replaying
    wr_group(5, 3'b001, 60, 20);
    do_draw("R10", 1, 0, 50, 5, 3'b001, 200, 3);
    do_draw("R10", 1, 0, 100, -1, 0, 0, 0);

    // R9: random traffic under random backpressure
    for (int it = 0; it < 40; it++) begin
      int nw;
      nw = $urandom % 4;
      for (int w = 0; w < nw; w++)
        wr_group($urandom % NG, 3'($urandom), $urandom % DEPTH, $urandom % 13);
      do_draw("R9", ($urandom % 100) < 80, $urandom % 4, 15 + ($urandom % 80), -1, 0, 0, 0);
    end

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

endmodule